// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar (seconds, minutes, hours, weekday, day of month, month, all in BCD) and raises an alarm when the time reaches a programmed target. Each of the six calendar fields has its own 8-bit target register. The top bit of a target register arms the comparison for that field, and the lower seven bits hold the BCD value. A field left disarmed is a don't-care, so a partial alarm is possible, for example "every day at 07 hours".

The comparison is evaluated only on the one-cycle second-update strobe from the calendar counter. When every armed field equals the calendar and at least one field is armed, a sticky alarm flag is set. A shared control register holds the flag and an interrupt enable. The interrupt output is the flag gated by the enable. Software reaches all registers over a simple single-cycle register bus. Read data is registered and appears one cycle after the read strobe.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every target register reads 0x00, the control register reads 0x00 and `alarm_irq` is low.
- R2: A bus write to index 8 (seconds), 9 (minutes), 10 (hours), 11 (weekday), 12 (day of month) or 13 (month) stores the byte, and a read of that index returns it on `bus_rdata` one cycle after the read strobe.
- R3: A target register whose bit 7 is 0 takes no part in the comparison, whatever its lower bits hold and whatever the calendar shows in that field.
- R4: On a cycle with `tick_1hz` high, the flag sets when at least one target has bit 7 set and every armed target's bits 6:0 equal its calendar field. A mismatch in any armed field, or no armed field at all, leaves the flag clear.
- R5: Without `tick_1hz`, a matching calendar never sets the flag.
- R6: The flag stays set until a write to control index 14 carries 0 in bit 0. Writing 1 to bit 0 never sets the flag and never clears it.
- R7: `alarm_irq` is high exactly when the flag and the enable are both set. It updates in the same cycle as the flag.
- R8: Control index 14 reads back with the flag in bit 0 and the interrupt enable in bit 3, and all other bits read 0. The enable takes bit 3 of every write to index 14.
- R9: When a matching tick and a flag-clearing write to index 14 fall in the same cycle, the flag ends set.
- R10: The month target is compared in the 1 to 12 BCD encoding as written, for example 0x12 for December.
- R11: Writes to indices other than 8 to 14 change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| tick_1hz | input | 1 | One-cycle second-update strobe |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 7 | Calendar hours, BCD |
| cal_wday | input | 7 | Calendar weekday, BCD |
| cal_mday | input | 7 | Calendar day of month, BCD |
| cal_mon | input | 7 | Calendar month, BCD 1 to 12 |
| alarm_irq | output | 1 | Alarm interrupt, registered |

## Verification
The two functions that can coincide are the match on a second tick and the software write that clears the flag. The bench first arms the seconds field with the interrupt enabled and the flag clear. It then issues a write of 0x08 to the control index in the very cycle that `tick_1hz` is high with a matching calendar. The outcome is judged through `alarm_irq` in the following cycle and a control-register readback of 0x09, which together show that the new match was not lost to the clear.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int ALM_BASE   = 8;
  localparam int CTRL_IDX   = 14;
  localparam int FLAG_BIT   = 0;
  localparam int IEN_BIT    = 3;
endpackage

// File: rtl/alarm_reg_file.sv
module alarm_reg_file
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NUM    = NUM_FIELDS,
  parameter int BASE   = ALM_BASE
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM-1:0][DATA_W-1:0]   regs
);
  for (genvar i = 0; i < NUM; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(BASE + i);

    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && addr == MY_IDX)
        regs[i] <= wdata;
    end

    // R11
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && addr == MY_IDX) |=> $stable(regs[i]));
  end
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match
  import alarm_cmp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM    = NUM_FIELDS,
  localparam int FW    = DATA_W - 1
) (
  input  logic [NUM-1:0][DATA_W-1:0] regs,
  input  logic [NUM-1:0][FW-1:0]     cal,
  output logic                       hit
);
  logic [NUM-1:0] armed;
  logic [NUM-1:0] ok;

  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    assign armed[i] = regs[i][DATA_W-1];
    assign ok[i]    = !armed[i] || (regs[i][FW-1:0] == cal[i]);
  end

  assign hit = (|armed) && (&ok);
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  logic ctrl_wr,
  input  logic wr_flag_bit,
  input  logic wr_ien_bit,
  output logic flag,
  output logic ien,
  output logic irq
);
  logic set_now;
  logic clr_now;
  logic flag_nx;
  logic ien_nx;

  assign set_now = tick && hit;
  assign clr_now = ctrl_wr && !wr_flag_bit;
  assign flag_nx = set_now || (flag && !clr_now);
  assign ien_nx  = ctrl_wr ? wr_ien_bit : ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ien  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nx;
      ien  <= ien_nx;
      irq  <= flag_nx && ien_nx;
    end
  end

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick && hit));
  // R5
  no_tick_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag && !tick) |=> !flag);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !(ctrl_wr && !wr_flag_bit)) |=> flag);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hit && ctrl_wr) |=> flag);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ien));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int FW    = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_1hz,
  input  logic [FW-1:0]     cal_sec,
  input  logic [FW-1:0]     cal_min,
  input  logic [FW-1:0]     cal_hour,
  input  logic [FW-1:0]     cal_wday,
  input  logic [FW-1:0]     cal_mday,
  input  logic [FW-1:0]     cal_mon,
  output logic              alarm_irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);

  logic [NUM_FIELDS-1:0][DATA_W-1:0] regs;
  logic [NUM_FIELDS-1:0][FW-1:0]     cal;
  logic                              hit;
  logic                              ctrl_wr;
  logic                              flag;
  logic                              ien;
  logic [DATA_W-1:0]                 rd_mux;

  assign cal     = {cal_mon, cal_mday, cal_wday, cal_hour, cal_min, cal_sec};
  assign ctrl_wr = bus_wr && bus_addr == CTRL_A;

  alarm_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(NUM_FIELDS), .BASE(ALM_BASE)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .regs(regs)
  );

  alarm_field_match #(.DATA_W(DATA_W), .NUM(NUM_FIELDS)) i_match (
    .regs(regs), .cal(cal), .hit(hit)
  );

  alarm_status i_status (
    .clk(clk), .rst(rst), .tick(tick_1hz), .hit(hit), .ctrl_wr(ctrl_wr),
    .wr_flag_bit(bus_wdata[FLAG_BIT]), .wr_ien_bit(bus_wdata[IEN_BIT]),
    .flag(flag), .ien(ien), .irq(alarm_irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (bus_addr == ADDR_W'(ALM_BASE + i)) rd_mux = regs[i];
    if (bus_addr == CTRL_A) begin
      rd_mux[FLAG_BIT] = flag;
      rd_mux[IEN_BIT]  = ien;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  // R2
  rd_update_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, tick_1hz = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] cal_sec = '0, cal_min = '0, cal_hour = '0;
  logic [6:0] cal_wday = '0, cal_mday = '0, cal_mon = 7'h01;
  logic       alarm_irq;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1hz(tick_1hz), .cal_sec(cal_sec), .cal_min(cal_min),
    .cal_hour(cal_hour), .cal_wday(cal_wday), .cal_mday(cal_mday),
    .cal_mon(cal_mon), .alarm_irq(alarm_irq)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read data appears
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic cyc(bit wr, bit rd, logic [3:0] a, logic [7:0] d, bit tk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_1hz = tk;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cyc(1'b0, 1'b1, a, 8'h00, 1'b0);
  endtask

  task automatic tick();
    cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1);
  endtask

  task automatic clear_all();
    for (int i = 8; i <= 13; i++) wr(4'(i), 8'h00);
    wr(4'd14, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int i = 8; i <= 13; i++) rd(4'(i), 8'h00, "R1 target reset");
    rd(4'd14, 8'h00, "R1 control reset");
    check(alarm_irq == 1'b0, "R1 irq reset", alarm_irq, 0);

    // R2 write and read back each target register
    for (int i = 8; i <= 13; i++) wr(4'(i), 8'(8'h10 + i));
    for (int i = 8; i <= 13; i++) rd(4'(i), 8'(8'h10 + i), "R2 readback");
    clear_all();

    // R4 seconds-only alarm, interrupt disabled -> flag only (R7)
    wr(4'd8, 8'hB0);
    cal_sec = 7'h30; cal_min = 7'h15;
    tick();
    check(alarm_irq == 1'b0, "R7 irq gated off", alarm_irq, 0);
    rd(4'd14, 8'h01, "R4 flag set on match");

    // R8 clear flag, set enable
    wr(4'd14, 8'h08);
    rd(4'd14, 8'h08, "R8 enable readback");
    // R5 matching but no tick
    repeat (5) @(negedge clk);
    check(alarm_irq == 1'b0, "R5 no tick no irq", alarm_irq, 0);
    rd(4'd14, 8'h08, "R5 flag stays clear");
    tick();
    check(alarm_irq == 1'b1, "R7 irq with enable", alarm_irq, 1);

    // R6 writing 1 to flag keeps it; enable drop removes irq
    wr(4'd14, 8'h09);
    rd(4'd14, 8'h09, "R6 write one keeps flag");
    wr(4'd14, 8'h01);
    check(alarm_irq == 1'b0, "R7 irq off when enable cleared", alarm_irq, 0);
    rd(4'd14, 8'h01, "R6 flag sticky");
    wr(4'd14, 8'h00);
    rd(4'd14, 8'h00, "R6 flag cleared by zero");
    // R6 writing 1 with flag clear does not set it
    wr(4'd14, 8'h01);
    rd(4'd14, 8'h00, "R6 write one cannot set");

    // R4 armed minutes mismatch
    wr(4'd9, 8'hC5);
    cal_min = 7'h44;
    tick();
    rd(4'd14, 8'h00, "R4 mismatch no flag");
    cal_min = 7'h45;
    tick();
    rd(4'd14, 8'h01, "R4 all armed match");
    wr(4'd14, 8'h00);

    // R3 disarmed hour with nonzero low bits is ignored
    wr(4'd10, 8'h07);
    cal_hour = 7'h10;
    tick();
    rd(4'd14, 8'h01, "R3 disarmed field ignored");
    wr(4'd14, 8'h00);

    // R4 nothing armed -> no flag
    clear_all();
    tick();
    rd(4'd14, 8'h00, "R4 none armed no flag");

    // R10 month alarm in 1..12 encoding
    wr(4'd13, 8'h92);
    cal_mon = 7'h11;
    tick();
    rd(4'd14, 8'h00, "R10 month 11 vs 12");
    cal_mon = 7'h12;
    tick();
    rd(4'd14, 8'h01, "R10 month 12 match");
    clear_all();

    // R9 clear write and matching tick in one cycle
    wr(4'd8, 8'hB0);
    wr(4'd14, 8'h08);
    cyc(1'b1, 1'b0, 4'd14, 8'h08, 1'b1);
    check(alarm_irq == 1'b1, "R9 set wins irq", alarm_irq, 1);
    rd(4'd14, 8'h09, "R9 set wins flag");
    clear_all();

    // R11 unmapped indices
    wr(4'd3, 8'hFF);
    wr(4'd15, 8'hFF);
    rd(4'd3, 8'h00, "R11 unmapped read 3");
    rd(4'd15, 8'h00, "R11 unmapped read 15");
    rd(4'd14, 8'h00, "R11 control untouched");
    for (int i = 8; i <= 13; i++) rd(4'(i), 8'h00, "R11 targets untouched");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule